// File: doc/BRIEF.md
# DMA Channel Interrupt Collector

This block gathers interrupt events from a bank of DMA channels and presents them to a processor through a small register window. Each channel can raise four kinds of event, each as a one-cycle pulse: the whole descriptor chain finished, one node of the chain finished, and two separate fault kinds. Every event kind has its own set of per-channel registers. A sticky raw latch records the event. An enable mask selects which raw bits count. A masked view shows the raw bits that the mask lets through.

A summary register folds the four masked views into one bit per channel, and a single interrupt line is high while any summary bit is set. Software finds the active channels from the summary and the masked views. It then clears the raw latches by writing ones at the bit positions it has handled. The register window also holds a writable channel priority word, where zero means every channel has equal weight. Register reads are combinational from the address; writes take effect at the clock edge.

Top module: `dma_irq_collector`

## Requirements
- R1: Reset clears every raw latch, every mask and the priority word, and holds `irq` low.
- R2: An event pulse on channel i of a class sets bit i of that class's raw latch at the next clock edge. The bit stays set until it is cleared. Class index: 0 = chain done, 1 = node done, 2 = fault A, 3 = fault B.
- R3: Raw latches are read at 0x600 + 8·class (0x600, 0x608, 0x610, 0x618). Writing there clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event pulse and a clearing write hit the same raw bit in the same cycle, the bit ends up set.
- R5: Mask registers at 0x18 + 4·class can be written and read back. Only the low N_CH bits are stored, and the upper read bits are zero. A mask bit of 1 enables that channel.
- R6: Masked views at 0x04 + 4·class read as the raw latch ANDed with the mask. Writes to these addresses change nothing.
- R7: The summary register at 0x00 has bit i equal to the OR of channel i's four masked bits. Writes to it change nothing.
- R8: `irq` is high exactly when the summary is nonzero. With every mask at zero, `irq` stays low.
- R9: The priority word at 0x688 stores a full DW-bit write and reads it back.
- R10: A read from any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_chain_done | input | N_CH | Per-channel chain-complete pulses |
| ev_node_done | input | N_CH | Per-channel node-complete pulses |
| ev_fault_a | input | N_CH | Per-channel fault A pulses |
| ev_fault_b | input | N_CH | Per-channel fault B pulses |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | DW | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | DW | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A raw latch that is wrong shows up on the same cycle at three places: its raw address, its masked address once the mask is set, and through the summary on `irq`. A stuck or dropped bit is therefore visible at the next read, one edge after the stimulus. A mask or clear that goes to the wrong channel or class leaves a bit set, or missing, at a position the sweep can predict. The sweep walks every channel of every class, so such a fault appears at the first channel it touches. The same-cycle event and clear case only shows when both arrive on one edge, and a wrong priority there leaves a zero in the raw read that follows.

// File: rtl/dma_irq_collector.sv
module dma_irq_collector #(
  parameter int N_CH = 16,
  parameter int AW   = 12,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] ev_chain_done,
  input  logic [N_CH-1:0] ev_node_done,
  input  logic [N_CH-1:0] ev_fault_a,
  input  logic [N_CH-1:0] ev_fault_b,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            reg_we,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq
);
  localparam int NCLS = 4;
  localparam logic [AW-1:0] A_SUM  = AW'('h000);
  localparam logic [AW-1:0] A_PRIO = AW'('h688);

  function automatic logic [AW-1:0] a_view(int k);
    return AW'(32'h004 + 4 * k);
  endfunction
  function automatic logic [AW-1:0] a_mask(int k);
    return AW'(32'h018 + 4 * k);
  endfunction
  function automatic logic [AW-1:0] a_raw(int k);
    return AW'(32'h600 + 8 * k);
  endfunction

  logic [NCLS-1:0][N_CH-1:0] ev, raw_q, mask_q, view;
  logic [N_CH-1:0] summary;
  logic [DW-1:0]   prio_q;

  assign ev = {ev_fault_b, ev_fault_a, ev_node_done, ev_chain_done};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
      prio_q <= '0;
    end else begin
      for (int k = 0; k < NCLS; k++) begin
        if (reg_we && reg_addr == a_raw(k))
          raw_q[k] <= (raw_q[k] & ~reg_wdata[N_CH-1:0]) | ev[k];
        else
          raw_q[k] <= raw_q[k] | ev[k];
        if (reg_we && reg_addr == a_mask(k))
          mask_q[k] <= reg_wdata[N_CH-1:0];
      end
      if (reg_we && reg_addr == A_PRIO)
        prio_q <= reg_wdata;
    end
  end

  assign view = raw_q & mask_q;

  always_comb begin
    summary = '0;
    for (int k = 0; k < NCLS; k++)
      summary = summary | view[k];
  end

  assign irq = |summary;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_SUM)  reg_rdata = DW'(summary);
    if (reg_addr == A_PRIO) reg_rdata = prio_q;
    for (int k = 0; k < NCLS; k++) begin
      if (reg_addr == a_view(k)) reg_rdata = DW'(view[k]);
      if (reg_addr == a_mask(k)) reg_rdata = DW'(mask_q[k]);
      if (reg_addr == a_raw(k))  reg_rdata = DW'(raw_q[k]);
    end
  end
endmodule

module dma_irq_collector_chk #(
  parameter int N_CH = 16,
  parameter int AW   = 12,
  parameter int DW   = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [N_CH-1:0]       ev_chain_done,
  input logic [N_CH-1:0]       ev_node_done,
  input logic [N_CH-1:0]       ev_fault_a,
  input logic [N_CH-1:0]       ev_fault_b,
  input logic [AW-1:0]         reg_addr,
  input logic [DW-1:0]         reg_wdata,
  input logic                  reg_we,
  input logic [DW-1:0]         reg_rdata,
  input logic                  irq,
  input logic [3:0][N_CH-1:0]  raw,
  input logic [3:0][N_CH-1:0]  msk,
  input logic [DW-1:0]         prio
);
  logic [3:0][N_CH-1:0] ev_all;
  logic raw_wr, mapped;
  assign ev_all = {ev_fault_b, ev_fault_a, ev_node_done, ev_chain_done};
  assign raw_wr = reg_we && (reg_addr == AW'('h600) || reg_addr == AW'('h608) ||
                             reg_addr == AW'('h610) || reg_addr == AW'('h618));
  assign mapped = reg_addr == AW'('h000) || reg_addr == AW'('h004) || reg_addr == AW'('h008) ||
                  reg_addr == AW'('h00C) || reg_addr == AW'('h010) || reg_addr == AW'('h018) ||
                  reg_addr == AW'('h01C) || reg_addr == AW'('h020) || reg_addr == AW'('h024) ||
                  reg_addr == AW'('h600) || reg_addr == AW'('h608) || reg_addr == AW'('h610) ||
                  reg_addr == AW'('h618) || reg_addr == AW'('h688);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (raw == '0 && msk == '0 && prio == '0 && !irq));

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_all) |=> ((raw & $past(ev_all)) == $past(ev_all)));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_wr |=> ((raw & $past(raw)) == $past(raw)));

  assert_event_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_wr && (|ev_chain_done) && reg_addr == AW'('h600)) |=>
      ((raw[0] & $past(ev_chain_done)) == $past(ev_chain_done)));

  assert_masked_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (msk == '0) |-> !irq);

  assert_prio_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'('h688)) |=> (prio == $past(reg_wdata)));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (reg_rdata == '0));
endmodule

bind dma_irq_collector dma_irq_collector_chk #(.N_CH(N_CH), .AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n),
  .ev_chain_done(ev_chain_done), .ev_node_done(ev_node_done),
  .ev_fault_a(ev_fault_a), .ev_fault_b(ev_fault_b),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
  .reg_rdata(reg_rdata), .irq(irq),
  .raw(raw_q), .msk(mask_q), .prio(prio_q)
);

// File: tb/test_dma_irq_collector.sv
module test_dma_irq_collector;
  localparam int CLK_P = 10;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] ev [4];
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic we = 1'b0, irq;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_irq_collector i_dma_irq_collector (
    .clk(clk), .rst_n(rst_n),
    .ev_chain_done(ev[0]), .ev_node_done(ev[1]), .ev_fault_a(ev[2]), .ev_fault_b(ev[3]),
    .reg_addr(addr), .reg_wdata(wdata), .reg_we(we), .reg_rdata(rdata), .irq(irq));

  function automatic logic [11:0] a_view(int k); return 12'(4 + 4*k); endfunction
  function automatic logic [11:0] a_mask(int k); return 12'('h18 + 4*k); endfunction
  function automatic logic [11:0] a_raw(int k);  return 12'('h600 + 8*k); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic pulse(int k, int i);
    @(negedge clk); ev[k][i] = 1'b1;
    @(negedge clk); ev[k][i] = 1'b0;
  endtask

  task automatic all_zero(string req);
    logic [31:0] d;
    rd(12'h000, d); chk(req, d, 0);
    rd(12'h688, d); chk(req, d, 0);
    for (int k = 0; k < 4; k++) begin
      rd(a_view(k), d); chk(req, d, 0);
      rd(a_mask(k), d); chk(req, d, 0);
      rd(a_raw(k), d);  chk(req, d, 0);
    end
    chk(req, {31'b0, irq}, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int k = 0; k < 4; k++) ev[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    all_zero("R1 reset");

    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < N; i++) begin
        logic [31:0] b;
        b = 32'(1) << i;
        pulse(k, i);
        rd(a_raw(k), d);  chk("R2 raw set", d, b);
        rd(a_view(k), d); chk("R6 masked off", d, 0);
        chk("R8 irq off", {31'b0, irq}, 0);
        wr(a_mask(k), b);
        rd(a_view(k), d); chk("R6 masked view", d, b);
        rd(12'h000, d);   chk("R7 summary", d, b);
        chk("R8 irq on", {31'b0, irq}, 1);
        wr(a_raw(k), ~b & 32'hFFFF);
        rd(a_raw(k), d);  chk("R3 zero bits keep", d, b);
        wr(a_raw(k), b);
        rd(a_raw(k), d);  chk("R3 one bit clears", d, 0);
        chk("R8 irq drops", {31'b0, irq}, 0);
        wr(a_mask(k), 0);
      end
    end

    // R4: event and clear on the same edge
    pulse(1, 5);
    @(negedge clk); addr = a_raw(1); wdata = 32'h20; we = 1'b1; ev[1][5] = 1'b1;
    @(negedge clk); we = 1'b0; ev[1][5] = 1'b0;
    rd(a_raw(1), d); chk("R4 event wins", d, 32'h20);
    wr(a_raw(1), 32'hFFFF);
    rd(a_raw(1), d); chk("R3 clear after R4", d, 0);

    // R6: masked view ignores writes
    pulse(0, 2);
    wr(12'h004, 32'hFFFF);
    rd(12'h004, d);   chk("R6 view write ignored", d, 0);
    rd(a_mask(0), d); chk("R6 mask untouched", d, 0);

    // R5: mask width
    wr(a_mask(2), 32'h1234ABCD);
    rd(a_mask(2), d); chk("R5 mask readback", d, 32'hABCD);
    wr(a_mask(2), 0);

    // R7: summary across classes
    pulse(0, 3); pulse(3, 3); pulse(1, 7);
    for (int k = 0; k < 4; k++) wr(a_mask(k), 32'hFFFF);
    rd(12'h000, d); chk("R7 multi-class summary", d, 32'h8C);
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, d); chk("R7 summary write ignored", d, 32'h8C);
    chk("R8 irq multi", {31'b0, irq}, 1);

    // R9: priority word
    wr(12'h688, 32'hDEADBEEF);
    rd(12'h688, d); chk("R9 prio store", d, 32'hDEADBEEF);
    wr(12'h688, 0);
    rd(12'h688, d); chk("R9 prio equal", d, 0);
    wr(12'h688, 32'h0000_5A5A);

    // R10: holes in the map
    rd(12'h014, d); chk("R10 unmapped 014", d, 0);
    rd(12'h604, d); chk("R10 unmapped 604", d, 0);
    rd(12'h680, d); chk("R10 unmapped 680", d, 0);
    rd(12'hFFC, d); chk("R10 unmapped FFC", d, 0);

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    all_zero("R1 mid-run reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule